// File: doc/BRIEF.md
# SCOAP Testability Calculator

This block works out combinational testability figures for a small levelized netlist of two-input AND and OR gates. The netlist is stored inside the block. For every net it produces three numbers: how hard the net is to drive to 0 (`cc0`), how hard it is to drive to 1 (`cc1`), and how hard it is to observe at a primary output (`co`). Test-generation heuristics use these numbers to choose which path to propagate a fault along, and which input to justify first.

Nets are numbered with the primary inputs first and the gate outputs after them, in gate order. Gate `g` drives net `NUM_PI + g`, and each of its two inputs may name only a lower-numbered net. Software loads the gate table through a write port and then pulses `start`. The block makes one forward sweep in gate order to fill in the controllabilities. It then makes one backward sweep in reverse order to fill in the observabilities, one gate per clock, and raises `done` for a single cycle. After that, any net can be read through a combinational read port.

Top module: `scoap_calc`

## Requirements
- R1: After reset `busy` and `done` are 0, and every net reads 0xFF in all three measures.
- R2: Writing with `cfg_we` sets gate `cfg_gate` to type OR when `cfg_or`=1 and AND when 0, with inputs `cfg_in_a`/`cfg_in_b` (net indices) and a primary-output flag `cfg_po`; writes made while `busy` is 1 are dropped.
- R3: A start sets each primary-input net to cc0=cc1=1 and co=0xFF, and each gate-output net to cc0=cc1=0xFF with co=0 if the gate is flagged as a primary output, else 0xFF.
- R4: For an AND gate, output cc0 = min(cc0 of the inputs)+1 and output cc1 = sum(cc1 of the inputs)+1.
- R5: For an OR gate, output cc1 = min(cc1 of the inputs)+1 and output cc0 = sum(cc0 of the inputs)+1.
- R6: Each input of a gate gets an observability candidate equal to output co + 1 plus the other input's cc1 (AND) or the other input's cc0 (OR).
- R7: When a net has several candidates (fanout, or both inputs of a gate tied to it, or primary-output status), the smallest is kept.
- R8: Values are 8 bits and 0xFF means infinity: any sum that has an operand of 0xFF, or whose result is above 0xFE, yields 0xFF.
- R9: A start while idle makes `busy` 1 from the next cycle. `done` is a one-cycle pulse 2·NUM_GATES cycles after the start edge, in the same cycle in which `busy` returns to 0.
- R10: A start pulse while `busy` is 1 is ignored and does not lengthen or restart the run.
- R11: Every start re-initializes all nets, so values from an earlier run never carry over.
- R12: `rd_cc0`, `rd_cc1` and `rd_co` show the current values of net `rd_net` combinationally; an index beyond the last net reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (idle only) |
| cfg_we | input | 1 | Gate table write enable |
| cfg_gate | input | 3 | Gate index to write |
| cfg_or | input | 1 | 1 = OR gate, 0 = AND gate |
| cfg_in_a | input | 4 | Net index of first input |
| cfg_in_b | input | 4 | Net index of second input |
| cfg_po | input | 1 | Gate output is a primary output |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_net | input | 4 | Net index to read |
| rd_cc0 | output | 8 | 0-controllability of `rd_net` |
| rd_cc1 | output | 8 | 1-controllability of `rd_net` |
| rd_co | output | 8 | Observability of `rd_net` |

## Verification
Some properties are checked by assertions on every cycle. These cover the control timing: the exact busy window, the single-cycle `done` pulse aligned with the fall of `busy`, the entry into `busy` after an idle start, the immunity of a run to a second start, and the stability of read data while the block is idle. The numeric content cannot be checked cycle by cycle. This covers the AND/OR rules, min-over-fanout, saturation at 0xFF and re-initialization between runs. The bench shows it by sweeping many pseudo-random levelized netlists plus directed ones (a saturating AND chain, a dropped primary output, writes and starts during a run) and comparing every net against arithmetic computed in the bench.

// File: rtl/scoap_pkg.sv
package scoap_pkg;

    localparam int VAL_W = 8;
    typedef logic [VAL_W-1:0] val_t;

    localparam val_t VAL_INF = '1;
    localparam val_t VAL_ONE = val_t'(1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FWD  = 2'd1,
        PH_BWD  = 2'd2
    } phase_e;

    // saturating add: infinity absorbs, anything at or above the code saturates
    function automatic val_t sat_add(val_t x, val_t y);
        logic [VAL_W:0] s;
        if (x == VAL_INF || y == VAL_INF) begin
            return VAL_INF;
        end
        s = {1'b0, x} + {1'b0, y};
        if (s >= {1'b0, VAL_INF}) begin
            return VAL_INF;
        end
        return s[VAL_W-1:0];
    endfunction

    function automatic val_t val_min(val_t x, val_t y);
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/scoap_fwd_eval.sv
module scoap_fwd_eval
    import scoap_pkg::*;
(
    input  logic is_or,
    input  val_t a_cc0,
    input  val_t a_cc1,
    input  val_t b_cc0,
    input  val_t b_cc1,
    output val_t y_cc0,
    output val_t y_cc1
);

    val_t min0, min1, sum0, sum1;

    always_comb begin
        min0 = val_min(a_cc0, b_cc0);
        min1 = val_min(a_cc1, b_cc1);
        sum0 = sat_add(a_cc0, b_cc0);
        sum1 = sat_add(a_cc1, b_cc1);
        if (is_or) begin
            y_cc0 = sat_add(sum0, VAL_ONE);
            y_cc1 = sat_add(min1, VAL_ONE);
        end else begin
            y_cc0 = sat_add(min0, VAL_ONE);
            y_cc1 = sat_add(sum1, VAL_ONE);
        end
    end

endmodule

// File: rtl/scoap_obs_eval.sv
module scoap_obs_eval
    import scoap_pkg::*;
(
    input  logic is_or,
    input  val_t out_co,
    input  val_t side_cc0,
    input  val_t side_cc1,
    output val_t cand
);

    val_t side;

    always_comb begin
        // the other input must hold the non-controlling value
        side = is_or ? side_cc0 : side_cc1;
        cand = sat_add(sat_add(out_co, side), VAL_ONE);
    end

endmodule

// File: rtl/scoap_sequencer.sv
module scoap_sequencer
    import scoap_pkg::*;
#(
    parameter int NUM_GATES = 8,
    localparam int GATE_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output phase_e            phase,
    output logic [GATE_W-1:0] gate_idx,
    output logic              init,
    output logic              done
);

    localparam logic [GATE_W-1:0] LAST_GATE = GATE_W'(NUM_GATES - 1);

    typedef struct packed {
        phase_e            phase;
        logic [GATE_W-1:0] idx;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_IDLE, idx: '0, done: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d.phase = PH_FWD;
                    seq_d.idx   = '0;
                end
            end
            PH_FWD: begin
                if (seq_q.idx == LAST_GATE) begin
                    seq_d.phase = PH_BWD;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            PH_BWD: begin
                if (seq_q.idx == '0) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx - 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase    = seq_q.phase;
    assign gate_idx = seq_q.idx;
    assign init     = (seq_q.phase == PH_IDLE) && start;
    assign done     = seq_q.done;

endmodule

// File: rtl/scoap_calc.sv
module scoap_calc
    import scoap_pkg::*;
#(
    parameter int NUM_PI    = 4,
    parameter int NUM_GATES = 8,
    localparam int NUM_NETS = NUM_PI + NUM_GATES,
    localparam int NET_W    = $clog2(NUM_NETS),
    localparam int GATE_W   = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_we,
    input  logic [GATE_W-1:0] cfg_gate,
    input  logic              cfg_or,
    input  logic [NET_W-1:0]  cfg_in_a,
    input  logic [NET_W-1:0]  cfg_in_b,
    input  logic              cfg_po,
    output logic              busy,
    output logic              done,
    input  logic [NET_W-1:0]  rd_net,
    output val_t              rd_cc0,
    output val_t              rd_cc1,
    output val_t              rd_co
);

    typedef struct packed {
        logic [NUM_GATES-1:0]            g_or;
        logic [NUM_GATES-1:0]            g_po;
        logic [NUM_GATES-1:0][NET_W-1:0] g_a;
        logic [NUM_GATES-1:0][NET_W-1:0] g_b;
        val_t [NUM_NETS-1:0]             cc0;
        val_t [NUM_NETS-1:0]             cc1;
        val_t [NUM_NETS-1:0]             co;
    } calc_t;

    calc_t calc_d, calc_q;

    // ---------------- sequencing ----------------
    phase_e            phase;
    logic [GATE_W-1:0] gate_idx;
    logic              init;

    scoap_sequencer #(.NUM_GATES(NUM_GATES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .phase    (phase),
        .gate_idx (gate_idx),
        .init     (init),
        .done     (done)
    );

    assign busy = (phase != PH_IDLE);

    // ---------------- current gate operands ----------------
    logic             cur_or;
    logic [NET_W-1:0] net_a, net_b, net_y;
    logic             a_ok, b_ok;
    val_t             a_cc0, a_cc1, b_cc0, b_cc1, y_co;
    val_t             f_cc0, f_cc1;

    always_comb begin
        cur_or = calc_q.g_or[gate_idx];
        net_a  = calc_q.g_a[gate_idx];
        net_b  = calc_q.g_b[gate_idx];
        net_y  = NET_W'(NUM_PI) + NET_W'(gate_idx);
        a_ok   = (int'(net_a) < NUM_NETS);
        b_ok   = (int'(net_b) < NUM_NETS);
        a_cc0  = a_ok ? calc_q.cc0[net_a] : VAL_INF;
        a_cc1  = a_ok ? calc_q.cc1[net_a] : VAL_INF;
        b_cc0  = b_ok ? calc_q.cc0[net_b] : VAL_INF;
        b_cc1  = b_ok ? calc_q.cc1[net_b] : VAL_INF;
        y_co   = calc_q.co[net_y];
    end

    scoap_fwd_eval u_fwd (
        .is_or (cur_or),
        .a_cc0 (a_cc0),
        .a_cc1 (a_cc1),
        .b_cc0 (b_cc0),
        .b_cc1 (b_cc1),
        .y_cc0 (f_cc0),
        .y_cc1 (f_cc1)
    );

    // observability candidates: index 0 -> input a (side b), 1 -> input b (side a)
    val_t side0 [2];
    val_t side1 [2];
    val_t cand  [2];

    assign side0[0] = b_cc0;
    assign side1[0] = b_cc1;
    assign side0[1] = a_cc0;
    assign side1[1] = a_cc1;

    for (genvar s = 0; s < 2; s++) begin : g_obs
        scoap_obs_eval u_obs (
            .is_or    (cur_or),
            .out_co   (y_co),
            .side_cc0 (side0[s]),
            .side_cc1 (side1[s]),
            .cand     (cand[s])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        calc_d = calc_q;

        if (cfg_we && !busy && (int'(cfg_gate) < NUM_GATES)) begin
            calc_d.g_or[cfg_gate] = cfg_or;
            calc_d.g_po[cfg_gate] = cfg_po;
            calc_d.g_a[cfg_gate]  = cfg_in_a;
            calc_d.g_b[cfg_gate]  = cfg_in_b;
        end

        if (init) begin
            for (int n = 0; n < NUM_NETS; n++) begin
                if (n < NUM_PI) begin
                    calc_d.cc0[n] = VAL_ONE;
                    calc_d.cc1[n] = VAL_ONE;
                    calc_d.co[n]  = VAL_INF;
                end else begin
                    calc_d.cc0[n] = VAL_INF;
                    calc_d.cc1[n] = VAL_INF;
                    calc_d.co[n]  = calc_q.g_po[n-NUM_PI] ? '0 : VAL_INF;
                end
            end
        end

        if (phase == PH_FWD) begin
            calc_d.cc0[net_y] = f_cc0;
            calc_d.cc1[net_y] = f_cc1;
        end

        if (phase == PH_BWD) begin
            if (a_ok) begin
                calc_d.co[net_a] = val_min(calc_q.co[net_a], cand[0]);
            end
            if (b_ok) begin
                // reads the updated entry so a gate with both pins on one net keeps the smaller
                calc_d.co[net_b] = val_min(calc_d.co[net_b], cand[1]);
            end
        end
    end

    localparam calc_t CALC_RST = '{
        g_or: '0,
        g_po: '0,
        g_a:  '0,
        g_b:  '0,
        cc0:  '1,
        cc1:  '1,
        co:   '1
    };

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            calc_q <= CALC_RST;
        end else begin
            calc_q <= calc_d;
        end
    end

    // ---------------- read port ----------------
    logic rd_ok;

    always_comb begin
        rd_ok  = (int'(rd_net) < NUM_NETS);
        rd_cc0 = rd_ok ? calc_q.cc0[rd_net] : VAL_INF;
        rd_cc1 = rd_ok ? calc_q.cc1[rd_net] : VAL_INF;
        rd_co  = rd_ok ? calc_q.co[rd_net]  : VAL_INF;
    end

endmodule

// File: rtl/scoap_calc_chk.sv
module scoap_calc_chk
    import scoap_pkg::*;
#(
    parameter int NUM_GATES = 8,
    parameter int NET_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [NET_W-1:0] rd_net,
    input val_t             rd_cc0,
    input val_t             rd_cc1,
    input val_t             rd_co
);

    localparam int RUN_CYCLES = 2 * NUM_GATES;

    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R10
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (int'(busy_cnt) == RUN_CYCLES));

    // R12
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=>
            ($stable(rd_net) |-> ($stable(rd_cc0) && $stable(rd_cc1) && $stable(rd_co))));

endmodule

bind scoap_calc scoap_calc_chk #(
    .NUM_GATES (NUM_GATES),
    .NET_W     (NET_W)
) u_scoap_calc_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .rd_net (rd_net),
    .rd_cc0 (rd_cc0),
    .rd_cc1 (rd_cc1),
    .rd_co  (rd_co)
);

// File: tb/test_scoap_calc.sv
`timescale 1ns/1ps
module test_scoap_calc;

    localparam int NPI = 4;
    localparam int NG  = 8;
    localparam int NN  = NPI + NG;
    localparam int INF = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_gate = '0;
    logic       cfg_or = 1'b0;
    logic [3:0] cfg_in_a = '0;
    logic [3:0] cfg_in_b = '0;
    logic       cfg_po = 1'b0;
    logic       busy, done;
    logic [3:0] rd_net = '0;
    logic [7:0] rd_cc0, rd_cc1, rd_co;

    always #10 clk = ~clk;

    scoap_calc #(.NUM_PI(NPI), .NUM_GATES(NG)) i_scoap_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_we(cfg_we), .cfg_gate(cfg_gate), .cfg_or(cfg_or),
        .cfg_in_a(cfg_in_a), .cfg_in_b(cfg_in_b), .cfg_po(cfg_po),
        .busy(busy), .done(done), .rd_net(rd_net),
        .rd_cc0(rd_cc0), .rd_cc1(rd_cc1), .rd_co(rd_co)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench copy of the netlist
    int t_or [NG];
    int t_a  [NG];
    int t_b  [NG];
    int t_po [NG];
    int e0 [NN];
    int e1 [NN];
    int eo [NN];
    int unsigned lfsr = 32'h1d2c_3b4a;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sadd(int x, int y);
        if (x == INF || y == INF) return INF;
        return (x + y > 254) ? INF : x + y;
    endfunction

    function automatic int imin(int x, int y);
        return (x < y) ? x : y;
    endfunction

    function automatic int unsigned rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // arithmetic model of R3..R8
    task automatic model();
        for (int n = 0; n < NN; n++) begin
            e0[n] = (n < NPI) ? 1 : INF;
            e1[n] = (n < NPI) ? 1 : INF;
            eo[n] = (n >= NPI && t_po[n-NPI] != 0) ? 0 : INF;
        end
        for (int g = 0; g < NG; g++) begin
            int a = t_a[g];
            int b = t_b[g];
            if (t_or[g] != 0) begin
                e0[NPI+g] = sadd(sadd(e0[a], e0[b]), 1);
                e1[NPI+g] = sadd(imin(e1[a], e1[b]), 1);
            end else begin
                e0[NPI+g] = sadd(imin(e0[a], e0[b]), 1);
                e1[NPI+g] = sadd(sadd(e1[a], e1[b]), 1);
            end
        end
        for (int g = NG - 1; g >= 0; g--) begin
            int a = t_a[g];
            int b = t_b[g];
            int sa = (t_or[g] != 0) ? e0[b] : e1[b];
            int sb = (t_or[g] != 0) ? e0[a] : e1[a];
            int ca = sadd(sadd(eo[NPI+g], sa), 1);
            int cb = sadd(sadd(eo[NPI+g], sb), 1);
            eo[a] = imin(eo[a], ca);
            eo[b] = imin(eo[b], cb);
        end
    endtask

    task automatic write_gate(int g, int o, int a, int b, int po);
        t_or[g] = o; t_a[g] = a; t_b[g] = b; t_po[g] = po;
        @(negedge clk);
        cfg_we = 1'b1; cfg_gate = 3'(g); cfg_or = 1'(o);
        cfg_in_a = 4'(a); cfg_in_b = 4'(b); cfg_po = 1'(po);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // start, then count cycles to done; optional extra start / config write mid-run
    task automatic run(string req, int poke_start_at, int poke_cfg_at);
        int k;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy after start", int'(busy), 1);
        k = 0;
        while (k < 40) begin
            @(negedge clk);
            k++;
            start  = (k == poke_start_at);
            cfg_we = (k == poke_cfg_at);
            if (k == poke_cfg_at) begin
                cfg_gate = 3'd0; cfg_or = ~1'(t_or[0]);
                cfg_in_a = 4'd3; cfg_in_b = 4'd2; cfg_po = 1'b1;
            end
            if (done) break;
            if (!busy) break;
        end
        start = 1'b0;
        cfg_we = 1'b0;
        check(req, "cycles to done", k, 2 * NG);
        check("R9", "busy low with done", int'(busy), 0);
        @(negedge clk);
        check("R9", "done one cycle", int'(done), 0);
    endtask

    task automatic compare_all(string req);
        model();
        for (int n = 0; n < NN; n++) begin
            rd_net = 4'(n);
            #1;
            check(req, $sformatf("net %0d cc0", n), int'(rd_cc0), e0[n]);
            check(req, $sformatf("net %0d cc1", n), int'(rd_cc1), e1[n]);
            check(req, $sformatf("net %0d co", n),  int'(rd_co),  eo[n]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < NG; g++) begin
            t_or[g] = 0; t_a[g] = 0; t_b[g] = 0; t_po[g] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        for (int n = 0; n < 16; n++) begin
            rd_net = 4'(n);
            #1;
            check("R1", "reset cc0", int'(rd_cc0), INF);
            check("R1", "reset co", int'(rd_co), INF);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6 R7: directed mixed netlist with fanout
        write_gate(0, 0, 0, 1, 0);
        write_gate(1, 1, 2, 3, 0);
        write_gate(2, 0, 4, 5, 0);
        write_gate(3, 1, 6, 1, 1);
        write_gate(4, 0, 4, 2, 0);
        write_gate(5, 1, 8, 7, 1);
        write_gate(6, 0, 9, 9, 0);
        write_gate(7, 1, 10, 0, 1);
        run("R9", 0, 0);
        compare_all("R4_R5_R6_R7");
        rd_net = 4'd4; #1;
        check("R4", "and cc0 direct", int'(rd_cc0), 2);
        check("R4", "and cc1 direct", int'(rd_cc1), 3);
        rd_net = 4'd5; #1;
        check("R5", "or cc0 direct", int'(rd_cc0), 3);
        check("R5", "or cc1 direct", int'(rd_cc1), 2);
        rd_net = 4'd15; #1;
        check("R12", "out of range cc1", int'(rd_cc1), INF);

        // R8 saturating AND chain, each gate with both pins on the previous net
        write_gate(0, 0, 0, 0, 0);
        for (int g = 1; g < NG; g++) write_gate(g, 0, NPI + g - 1, NPI + g - 1, (g == NG - 1) ? 1 : 0);
        run("R9", 0, 0);
        compare_all("R8");
        rd_net = 4'(NPI + 5); #1;
        check("R8", "cc1 127 before saturation", int'(rd_cc1), 127);
        rd_net = 4'(NPI + 6); #1;
        check("R8", "cc1 saturates", int'(rd_cc1), INF);
        check("R8", "cc0 stays finite", int'(rd_cc0), 8);

        // R10 + R2: start and a config write during the run are ignored
        run("R10", 5, 3);
        compare_all("R2_R10");

        // R11: drop the only primary output, re-run, observabilities must reset
        write_gate(NG - 1, 0, NPI + NG - 2, NPI + NG - 2, 0);
        run("R11", 0, 0);
        compare_all("R11");
        rd_net = 4'(NPI); #1;
        check("R11", "co no longer observable", int'(rd_co), INF);

        // R3..R8 sweep over pseudo-random levelized netlists
        for (int t = 0; t < 40; t++) begin
            for (int g = 0; g < NG; g++) begin
                int unsigned r = rnd();
                write_gate(g, int'(r & 1), int'((r >> 1) % (NPI + g)),
                           int'((r >> 9) % (NPI + g)),
                           (g == NG - 1) ? 1 : int'((r >> 20) & 1));
            end
            run("R9", 0, 0);
            compare_all("R3_R6_R7");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule